// File: doc/BRIEF.md
# Scan-Out Line Address Generator

This block supplies the frame-buffer read address for every scanline that the display pipeline shows. Software writes a frame origin, in 8-byte (qword) units, and a line stride, in 16-byte units. These values land in shadow copies. The shadow copies reach the working registers only when vertical blanking begins, so a pan or a page flip never shows up part way down a visible frame.

The display timing generator supplies a frame strobe and a line strobe. The frame strobe marks the start of the first visible line, and the line strobe marks the start of each line after it. On the frame strobe, the line base address is loaded with the working origin. On each line strobe, the line base advances by twice the stride, because one 16-byte stride unit is two qwords. The running fetch address restarts at the line base on every strobe.

The running fetch address is presented as a valid/ready stream. It is valid whenever vertical blanking is low. It moves on by one qword in each cycle where the consumer accepts it. When the consumer holds ready low, the address is held. All arithmetic wraps modulo 2^22 qwords.

Top module: `scan_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no other stimulus, `line_base_o` and `fetch_addr_o` are 0, and the working origin and stride are 0.
- R2: A cycle with `upd_req_i` high captures `start_qw_i` and `pitch_i` into the shadow registers. The outputs do not reflect the captured values before the next commit.
- R3: The shadow values are copied into the working registers only in a cycle where `vblank_i` is high and was low in the previous cycle (a rising edge). Holding `vblank_i` high does not copy again. A shadow update made while `vblank_i` stays high waits for the next rising edge.
- R4: In the cycle after `frame_start_i` is high, both `line_base_o` and `fetch_addr_o` equal the working origin as it stood before that edge.
- R5: In the cycle after `line_start_i` is high (with `frame_start_i` low), `line_base_o` equals the previous base plus 2 × working stride, modulo 2^22. `fetch_addr_o` equals that same new base.
- R6: `fetch_vld_o` equals the inverse of `vblank_i`. Each cycle with `fetch_vld_o` and `fetch_rdy_i` both high and no strobe advances `fetch_addr_o` by 1, wrapping from 0x3FFFFF to 0.
- R7: Strobe priority is frame strobe, then line strobe, then fetch handshake. A lower-priority event in the same cycle as a higher one has no effect.
- R8: When `fetch_rdy_i` is low, or when `vblank_i` is high, and no strobe is present, `fetch_addr_o` and `line_base_o` are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_qw_i | input | 22 | Frame origin in qword units, captured on update |
| pitch_i | input | 10 | Line stride in 16-byte units, captured on update |
| upd_req_i | input | 1 | Load origin and stride into the shadow registers |
| vblank_i | input | 1 | Vertical blanking; rising edge commits the shadow registers |
| frame_start_i | input | 1 | First visible line of a frame begins |
| line_start_i | input | 1 | A subsequent visible line begins |
| fetch_rdy_i | input | 1 | Consumer accepts the current fetch address |
| fetch_vld_o | output | 1 | Fetch address valid (active display) |
| line_base_o | output | 22 | Base qword address of the current line |
| fetch_addr_o | output | 22 | Running qword fetch address |

## Verification
The bench probes two kinds of commit error. It makes a shadow update mid-frame, and it makes another while blanking is held high. A design that committed on the level of blanking, or that wrote straight through to the working registers, would move the line base before the next blanking edge. An origin near the top of the address space, paired with the largest stride, tests the wrap. A design that carried out of 22 bits, or that added the stride unscaled, would produce wrong line bases and fetch addresses. Strobes that coincide with each other and with accepted fetches expose a wrong priority order. Long stretches with ready low, and with blanking high, catch an address that creeps forward without a handshake.

// File: rtl/scan_pkg.sv
package scan_pkg;
  parameter int ADDR_W  = 22;
  parameter int PITCH_W = 10;
  typedef logic [ADDR_W-1:0]  qaddr_t;
  typedef logic [PITCH_W-1:0] pitch_t;
endpackage

// File: rtl/scan_shadow.sv
module scan_shadow #(
  parameter int ADDR_W  = scan_pkg::ADDR_W,
  parameter int PITCH_W = scan_pkg::PITCH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  start_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic               upd_i,
  input  logic               vblank_i,
  output logic [ADDR_W-1:0]  work_start_o,
  output logic [PITCH_W-1:0] work_pitch_o
);
  logic [ADDR_W-1:0]  sh_start;
  logic [PITCH_W-1:0] sh_pitch;
  logic               vb_q;
  logic               commit;

  assign commit = vblank_i && !vb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_start     <= '0;
      sh_pitch     <= '0;
      vb_q         <= 1'b0;
      work_start_o <= '0;
      work_pitch_o <= '0;
    end else begin
      vb_q <= vblank_i;
      if (upd_i) begin
        sh_start <= start_i;
        sh_pitch <= pitch_i;
      end
      if (commit) begin
        work_start_o <= sh_start;
        work_pitch_o <= sh_pitch;
      end
    end
  end

  // working registers move only on a blanking rising edge
  p_commit_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(work_start_o) || !$stable(work_pitch_o)) |-> $past(vblank_i) && !$past(vb_q));
endmodule

// File: rtl/scan_addr_step.sv
module scan_addr_step #(
  parameter int ADDR_W  = scan_pkg::ADDR_W,
  parameter int PITCH_W = scan_pkg::PITCH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_i,
  input  logic               line_i,
  input  logic               take_i,
  input  logic [ADDR_W-1:0]  work_start_i,
  input  logic [PITCH_W-1:0] work_pitch_i,
  output logic [ADDR_W-1:0]  base_o,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int STEP_W = PITCH_W + 1;

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] next_base;

  generate
    if (ADDR_W > STEP_W) begin : g_ext
      assign step = {{(ADDR_W-STEP_W){1'b0}}, work_pitch_i, 1'b0};
    end else begin : g_trunc
      logic [STEP_W-1:0] wide;
      assign wide = {work_pitch_i, 1'b0};
      assign step = wide[ADDR_W-1:0];
    end
  endgenerate

  assign next_base = base_o + step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_o <= '0;
      addr_o <= '0;
    end else if (frame_i) begin
      base_o <= work_start_i;
      addr_o <= work_start_i;
    end else if (line_i) begin
      base_o <= next_base;
      addr_o <= next_base;
    end else if (take_i) begin
      addr_o <= addr_o + 1'b1;
    end
  end

  p_frame_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> (base_o == $past(work_start_i)) && (addr_o == $past(work_start_i)));
  p_line_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_i && !frame_i) |=> (addr_o == base_o) && !$stable(base_o) || ($past(work_pitch_i) == '0));
  p_fetch_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !line_i && !frame_i) |=> addr_o == $past(addr_o) + 1'b1);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !line_i && !frame_i) |=> $stable(addr_o) && $stable(base_o));
endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen #(
  parameter int ADDR_W  = scan_pkg::ADDR_W,
  parameter int PITCH_W = scan_pkg::PITCH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  start_qw_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic               upd_req_i,
  input  logic               vblank_i,
  input  logic               frame_start_i,
  input  logic               line_start_i,
  input  logic               fetch_rdy_i,
  output logic               fetch_vld_o,
  output logic [ADDR_W-1:0]  line_base_o,
  output logic [ADDR_W-1:0]  fetch_addr_o
);
  logic [ADDR_W-1:0]  work_start;
  logic [PITCH_W-1:0] work_pitch;
  logic               take;

  assign fetch_vld_o = !vblank_i;
  assign take        = fetch_vld_o && fetch_rdy_i;

  scan_shadow #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_shadow (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_qw_i),
    .pitch_i      (pitch_i),
    .upd_i        (upd_req_i),
    .vblank_i     (vblank_i),
    .work_start_o (work_start),
    .work_pitch_o (work_pitch)
  );

  scan_addr_step #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_step (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_i      (frame_start_i),
    .line_i       (line_start_i),
    .take_i       (take),
    .work_start_i (work_start),
    .work_pitch_i (work_pitch),
    .base_o       (line_base_o),
    .addr_o       (fetch_addr_o)
  );

  // frame strobe beats a coincident line strobe
  p_frame_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && line_start_i) |=> line_base_o == $past(work_start));
  p_reset_zero_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (line_base_o == '0) && (fetch_addr_o == '0));
endmodule

// File: tb/tb_scan_addr_gen.sv
module tb_scan_addr_gen;
  localparam int MASK = 32'h3FFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] start_qw_i = '0;
  logic [9:0]  pitch_i = '0;
  logic        upd_req_i = 1'b0;
  logic        vblank_i = 1'b0;
  logic        frame_start_i = 1'b0;
  logic        line_start_i = 1'b0;
  logic        fetch_rdy_i = 1'b0;
  logic        fetch_vld_o;
  logic [21:0] line_base_o;
  logic [21:0] fetch_addr_o;

  int n_vec = 0;
  int n_bad = 0;
  string phase = "R1";

  // behavioural reference
  int m_ss = 0, m_sp = 0, m_ws = 0, m_wp = 0, m_base = 0, m_fa = 0;
  bit m_vbq = 0;

  always #10 clk = ~clk;

  scan_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .start_qw_i(start_qw_i), .pitch_i(pitch_i),
    .upd_req_i(upd_req_i), .vblank_i(vblank_i), .frame_start_i(frame_start_i),
    .line_start_i(line_start_i), .fetch_rdy_i(fetch_rdy_i),
    .fetch_vld_o(fetch_vld_o), .line_base_o(line_base_o), .fetch_addr_o(fetch_addr_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ss = 0; m_sp = 0; m_ws = 0; m_wp = 0; m_base = 0; m_fa = 0; m_vbq = 0;
    end else begin
      int ows, owp;
      ows = m_ws; owp = m_wp;
      if (vblank_i && !m_vbq) begin m_ws = m_ss; m_wp = m_sp; end
      if (upd_req_i) begin m_ss = int'(start_qw_i); m_sp = int'(pitch_i); end
      m_vbq = vblank_i;
      if (frame_start_i) begin m_base = ows; m_fa = ows; end
      else if (line_start_i) begin m_base = (m_base + 2 * owp) & MASK; m_fa = m_base; end
      else if (!vblank_i && fetch_rdy_i) m_fa = (m_fa + 1) & MASK;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk({phase, " base"}, int'(line_base_o), m_base);
    chk({phase, " addr"}, int'(fetch_addr_o), m_fa);
    chk({phase, " vld"}, int'(fetch_vld_o), int'(!vblank_i));
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic strobe_frame();
    frame_start_i = 1'b1; step(1); frame_start_i = 1'b0;
  endtask

  task automatic strobe_line();
    line_start_i = 1'b1; step(1); line_start_i = 1'b0;
  endtask

  task automatic shadow(input int s, input int p);
    start_qw_i = 22'(s); pitch_i = 10'(p); upd_req_i = 1'b1; step(1); upd_req_i = 1'b0;
  endtask

  task automatic vb_pulse();
    vblank_i = 1'b1; step(3); vblank_i = 1'b0; step(1);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    step(3);
    #8; chk("R1 reset base", int'(line_base_o), 0); chk("R1 reset addr", int'(fetch_addr_o), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    step(2);
    phase = "R2";
    shadow(32'h1000, 32'h50);
    strobe_frame(); fetch_rdy_i = 1'b1; step(4); strobe_line(); step(2);
    phase = "R3";
    vb_pulse(); strobe_frame();
    #8; chk("R3 committed origin", int'(line_base_o), 32'h1000); #2;
    phase = "R5";
    strobe_line();
    #8; chk("R5 stride step", int'(line_base_o), 32'h10A0); #2;
    phase = "R8";
    fetch_rdy_i = 1'b0; step(5);
    vblank_i = 1'b1; fetch_rdy_i = 1'b1; step(1);
    phase = "R3";
    shadow(32'h2000, 32'h10); step(3); vblank_i = 1'b0; step(1);
    strobe_frame();
    #8; chk("R3 held-vblank update not committed", int'(line_base_o), 32'h1000); #2;
    vb_pulse(); strobe_frame();
    #8; chk("R3 next edge commits", int'(line_base_o), 32'h2000); #2;
    phase = "R6";
    shadow(32'h3FFFF0, 32'h3FF); vb_pulse(); strobe_frame(); step(40);
    strobe_line();
    #8; chk("R5 wrap stride", int'(line_base_o), (32'h3FFFF0 + 32'h7FE) & MASK); #2;
    phase = "R7";
    frame_start_i = 1'b1; line_start_i = 1'b1; step(1);
    frame_start_i = 1'b0; step(1); line_start_i = 1'b0;
    #8; chk("R7 frame beats line", int'(fetch_addr_o), (32'h3FFFF0 + 32'h7FE) & MASK); #2;
    phase = "R8";
    for (int i = 0; i < 3000; i++) begin
      fetch_rdy_i   = 1'($urandom_range(0, 1));
      line_start_i  = ($urandom_range(0, 15) == 0);
      frame_start_i = ($urandom_range(0, 63) == 0);
      vblank_i      = ($urandom_range(0, 9) == 0) ? ~vblank_i : vblank_i;
      upd_req_i     = ($urandom_range(0, 31) == 0);
      start_qw_i    = 22'($urandom);
      pitch_i       = 10'($urandom);
      step(1);
    end
    upd_req_i = 0; line_start_i = 0; frame_start_i = 0; vblank_i = 0;
    step(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule